// File: doc/BRIEF.md
# Code-Selected Bitwise Unit with Bus Release

This block takes two operand words and a 2-bit function code and places exactly one bitwise function of the operands onto a shared data bus. The code is decoded into one-hot, active-high function enables, so two results can never reach the bus at the same time. Three codes each pick a function: exclusive OR, AND, or inclusive OR. The fourth code, all zeros, picks none. In that case the block withdraws from the bus so that another device on the same bus can drive it.

The bus output comes with a drive-enable flag, `drive_en_o`. A system-level bus multiplexer or an arbiter checker can use this flag. A parameter chooses how the bus output is built. The gated variant, which is the default, forces the word to zero when idle, so it fits an AND-OR bus multiplexer. The tri-state variant puts high impedance on the word when idle. The data width is a parameter with a default of 8 bits.

Top module: `lu_bus_unit`

## Requirements
- R1: With function code 2'b01 the bus carries the bitwise exclusive OR of the two operands and `drive_en_o` is 1.
- R2: With function code 2'b10 the bus carries the bitwise AND of the two operands and `drive_en_o` is 1.
- R3: With function code 2'b11 the bus carries the bitwise inclusive OR of the two operands and `drive_en_o` is 1.
- R4: With function code 2'b00 no function is performed and `drive_en_o` is 0. In the default gated variant the bus word is all zeros whatever the operands are.
- R5: The decoded function enables are active high, and at most one of them is asserted at any time. `drive_en_o` is 1 exactly when the code is non-zero.
- R6: The bus value depends only on the selected function. If the operands are held and only the code changes, the bus moves to the newly selected result with no residue from the previous one.
- R7: The data width is set by the parameter `WIDTH` (default 8, minimum 1). Every bit position obeys R1 to R4 independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand word |
| opb_i | input | WIDTH | Second operand word |
| fsel_i | input | 2 | Function code: 00 idle, 01 XOR, 10 AND, 11 OR |
| bus_o | output | WIDTH | Value placed on the shared bus (zero or high impedance when idle) |
| drive_en_o | output | 1 | High while the block is driving the bus |

## Verification
The embedded assertions check on every input change that:
- at most one decoded enable is set;
- `drive_en_o` follows a non-zero code;
- the idle word is zero in the gated variant;
- whenever a function enable is high, the bus equals that function of the operand ports.

Only the bench's scenarios can show that every code and operand pair maps to the right bus word, because they sweep every combination on a narrow instance. They also show that a code change with steady operands leaves no trace of the old result, and that the full-width default instance behaves bit for bit like the narrow one.

// File: rtl/lu_pkg.sv
package lu_pkg;

   typedef enum logic [1:0] {
      FN_IDLE = 2'b00,
      FN_XOR  = 2'b01,
      FN_AND  = 2'b10,
      FN_OR   = 2'b11
   } fn_code_e;

   typedef enum logic {
      DRV_GATED    = 1'b0,
      DRV_TRISTATE = 1'b1
   } drv_style_e;

   localparam int unsigned CODE_W = 2;
   localparam int unsigned NUM_CODES = 1 << CODE_W;

endpackage

// File: rtl/lu_decode.sv
module lu_decode
   import lu_pkg::*;
(
   input  logic [CODE_W-1:0]    code_i,
   output logic [NUM_CODES-1:0] sel_o
);

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_dec
      assign sel_o[k] = (code_i == CODE_W'(k));
   end

   // R5: decoder outputs never overlap
   always_comb begin
      if (!$isunknown(code_i))
         a_r5_dec_onehot: assert ($onehot(sel_o))
            else $error("decoder output not one-hot");
   end

endmodule

// File: rtl/lu_funcs.sv
module lu_funcs #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] xor_o,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign xor_o[i] = a_i[i] ^ b_i[i];
      assign and_o[i] = a_i[i] & b_i[i];
      assign or_o[i]  = a_i[i] | b_i[i];
   end

endmodule

// File: rtl/lu_busdrv.sv
module lu_busdrv
   import lu_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter drv_style_e  STYLE = DRV_GATED
) (
   input  logic             en_xor_i,
   input  logic             en_and_i,
   input  logic             en_or_i,
   input  logic [WIDTH-1:0] xor_i,
   input  logic [WIDTH-1:0] and_i,
   input  logic [WIDTH-1:0] or_i,
   output logic [WIDTH-1:0] bus_o,
   output logic             drive_o
);

   logic [WIDTH-1:0] merged;

   assign merged  = ({WIDTH{en_xor_i}} & xor_i)
                  | ({WIDTH{en_and_i}} & and_i)
                  | ({WIDTH{en_or_i}}  & or_i);
   assign drive_o = en_xor_i | en_and_i | en_or_i;

   if (STYLE == DRV_TRISTATE) begin : g_tri
      assign bus_o = drive_o ? merged : {WIDTH{1'bz}};
   end else begin : g_gated
      assign bus_o = merged;

      // R4: a released gated bus contributes nothing to the bus mux
      always_comb begin
         if (!$isunknown({en_xor_i, en_and_i, en_or_i}) && !drive_o)
            a_r4_idle_zero: assert (bus_o == '0)
               else $error("idle bus word not zero");
      end
   end

endmodule

// File: rtl/lu_bus_unit.sv
module lu_bus_unit
   import lu_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter drv_style_e  STYLE = DRV_GATED
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [1:0]       fsel_i,
   output logic [WIDTH-1:0] bus_o,
   output logic             drive_en_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("lu_bus_unit: WIDTH must be at least 1");
   end

   logic [NUM_CODES-1:0] sel;
   logic [WIDTH-1:0]     v_xor, v_and, v_or;

   lu_decode u_dec (
      .code_i (fsel_i),
      .sel_o  (sel)
   );

   lu_funcs #(.WIDTH(WIDTH)) u_fn (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .xor_o (v_xor),
      .and_o (v_and),
      .or_o  (v_or)
   );

   lu_busdrv #(.WIDTH(WIDTH), .STYLE(STYLE)) u_drv (
      .en_xor_i (sel[FN_XOR]),
      .en_and_i (sel[FN_AND]),
      .en_or_i  (sel[FN_OR]),
      .xor_i    (v_xor),
      .and_i    (v_and),
      .or_i     (v_or),
      .bus_o    (bus_o),
      .drive_o  (drive_en_o)
   );

   always_comb begin
      if (!$isunknown({fsel_i, opa_i, opb_i})) begin
         // R5: drive flag tracks a non-idle code
         a_r5_drive_flag: assert (drive_en_o == (fsel_i != FN_IDLE))
            else $error("drive_en_o mismatch");
         // R1
         if (sel[FN_XOR])
            a_r1_xor_on_bus: assert (bus_o == (opa_i ^ opb_i))
               else $error("xor result wrong");
         // R2
         if (sel[FN_AND])
            a_r2_and_on_bus: assert (bus_o == (opa_i & opb_i))
               else $error("and result wrong");
         // R3
         if (sel[FN_OR])
            a_r3_or_on_bus: assert (bus_o == (opa_i | opb_i))
               else $error("or result wrong");
      end
   end

endmodule

// File: tb/sim_lu_bus_unit.sv
module sim_lu_bus_unit;

   localparam int unsigned NW = 4;
   localparam int unsigned WW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [NW-1:0] a0, b0, y0;
   logic [1:0]    f0;
   logic          d0;

   logic [WW-1:0] a1, b1, y1;
   logic [1:0]    f1;
   logic          d1;

   lu_bus_unit #(.WIDTH(NW)) u0 (
      .opa_i(a0), .opb_i(b0), .fsel_i(f0), .bus_o(y0), .drive_en_o(d0));

   lu_bus_unit u1 (
      .opa_i(a1), .opb_i(b1), .fsel_i(f1), .bus_o(y1), .drive_en_o(d1));

   function automatic logic [WW-1:0] model(input logic [1:0] f,
                                           input logic [WW-1:0] a,
                                           input logic [WW-1:0] b);
      logic [WW-1:0] r;
      r = '0;
      for (int i = 0; i < int'(WW); i++) begin
         int ai = int'(a[i]);
         int bi = int'(b[i]);
         case (f)
            2'b01: r[i] = ((ai + bi) % 2) == 1;
            2'b10: r[i] = (ai * bi) == 1;
            2'b11: r[i] = (ai + bi) > 0;
            default: r[i] = 1'b0;
         endcase
      end
      return r;
   endfunction

   function automatic string req_of(input logic [1:0] f);
      case (f)
         2'b01: return "R1";
         2'b10: return "R2";
         2'b11: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [WW-1:0] act,
                      input logic [WW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      logic [WW-1:0] prev;
      a0 = '0; b0 = '0; f0 = 2'b00;
      a1 = '0; b1 = '0; f1 = 2'b00;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R4: idle state after start, operands non-zero
      @(posedge clk); a0 = 4'hF; b0 = 4'hA; f0 = 2'b00;
      @(negedge clk);
      chk("R4 idle drive", WW'(d0), '0);
      chk("R4 idle word", WW'(y0), '0);

      // R1..R5, R7: exhaustive sweep on the narrow instance
      for (int f = 0; f < 4; f++) begin
         for (int a = 0; a < (1 << NW); a++) begin
            for (int b = 0; b < (1 << NW); b++) begin
               @(posedge clk);
               f0 = 2'(f); a0 = NW'(a); b0 = NW'(b);
               @(negedge clk);
               chk({req_of(2'(f)), " word"}, WW'(y0),
                   WW'(NW'(model(2'(f), WW'(a), WW'(b)))));
               // R5: drive flag high exactly for non-zero codes
               chk("R5 drive", WW'(d0), WW'(f != 0));
            end
         end
      end

      // R6: hold operands, walk the codes in several orders
      @(posedge clk); a0 = 4'b1100; b0 = 4'b1010;
      for (int s = 0; s < 3; s++) begin
         for (int k = 0; k < 4; k++) begin
            int f;
            f = (k * (s + 1) + s) % 4;
            @(posedge clk); f0 = 2'(f);
            @(negedge clk);
            chk("R6 code walk", WW'(y0),
                WW'(NW'(model(2'(f), WW'(4'b1100), WW'(4'b1010)))));
         end
      end

      // R7: default-width instance, walking-one and mixed patterns
      for (int i = 0; i < int'(WW); i++) begin
         for (int f = 0; f < 4; f++) begin
            @(posedge clk);
            a1 = WW'(1) << i; b1 = ~(WW'(3) << i) ^ 8'h5A; f1 = 2'(f);
            @(negedge clk);
            chk({"R7 ", req_of(2'(f))}, y1, model(2'(f), a1, b1));
            chk("R7 drive", WW'(d1), WW'(f != 0));
         end
      end
      @(posedge clk); a1 = 8'hFF; b1 = 8'hFF; f1 = 2'b11;
      @(negedge clk); prev = y1;
      chk("R3 full", prev, 8'hFF);
      @(posedge clk); f1 = 2'b00;
      @(negedge clk);
      chk("R4 release full", y1, 8'h00);
      chk("R4 drive full", WW'(d1), '0);
      @(posedge clk); f1 = 2'b01;
      @(negedge clk);
      chk("R1 equal operands", y1, 8'h00);
      chk("R6 no residue", WW'(d1), WW'(1));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule